// File: doc/BRIEF.md
# Complementary Pair Break Controller

This block sits between the compare stage of a timer channel and a pair of output pins, one main and one complementary. In normal running it takes the compare reference and builds the two pin levels from it. A gap of inactive time is inserted each time the reference changes, so the two outputs are never active together. A per-output polarity bit sets which level counts as inactive.

A break input moves the pair into a safe state in two phases. The first phase is immediate and needs no clock: both pins drop to their polarity (inactive) levels. Depending on a variant select, the tristate enables are then either dropped, so the pins float, or kept, so the pins are driven. The break is also passed through a synchronizer. A programmable number of clock cycles after its synchronized rising edge, the pins move to configured idle levels. When the synchronized break falls, the block resumes normal operation at the next clock edge, and the dead-time rule applies again.

Two flags report bad settings: idle levels that would make both outputs active together, and polarity or idle bits left set on a pair whose two outputs are both unused.

Top module: `cpair_brk_ctrl`

## Requirements
- R1: While `brk_in` is high, and before the idle phase starts, `pin_main` equals `pol_main` and `pin_comp` equals `pol_comp`. This takes effect combinationally, with no clock edge needed.
- R2: With `off_sel` = 0 (float variant), both `pin_main_oe` and `pin_comp_oe` are 0 whenever break is active, either through `brk_in` or through a break phase that has not yet been released.
- R3: With `off_sel` = 1 (driven off-state variant), during break `pin_main_oe` equals `en_main` and `pin_comp_oe` equals `en_comp`.
- R4: The forced phase starts at the first rising edge at which the 2-stage synchronized break is high. This is the third edge after `brk_in` rises. After max(`dead_time`,1) further edges the pins show `idle_main` and `idle_comp`, and they hold those levels until release.
- R5: When `en_main` and `en_comp` are both 0, both output enables are 0 in every state.
- R6: An output is active when its pin differs from its polarity bit. `idle_conflict` is 1 exactly when `idle_main` differs from `pol_main` and `idle_comp` differs from `pol_comp`.
- R7: `unused_cfg_err` is 1 exactly when both enables are 0 and any of `pol_main`, `pol_comp`, `idle_main`, `idle_comp` is 1.
- R8: In normal operation, `pin_main` = `pol_main` XOR main_on and `pin_comp` = `pol_comp` XOR comp_on. main_on can be 1 only while `oc_ref` = 1, and comp_on only while `oc_ref` = 0. The two outputs are never active together.
- R9: At the first edge that sees `oc_ref` changed, both outputs become inactive. The output that the new reference value selects becomes active max(`dead_time`,1) edges after that edge.
- R10: At the first edge after the synchronized break falls, the block returns to normal. At that point both pins are at their polarity levels and the enables follow `en_main`/`en_comp`. The selected output becomes active max(`dead_time`,1) edges later.
- R11: A synchronous `rst` returns the block to the normal phase with both outputs inactive, even from the idle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_in | input | 1 | Asynchronous break request, active high |
| oc_ref | input | 1 | Compare reference: 1 selects the main output, 0 the complementary |
| pol_main | input | 1 | Inactive level of the main pin |
| pol_comp | input | 1 | Inactive level of the complementary pin |
| idle_main | input | 1 | Main pin level in the idle phase |
| idle_comp | input | 1 | Complementary pin level in the idle phase |
| en_main | input | 1 | Main output enable |
| en_comp | input | 1 | Complementary output enable |
| off_sel | input | 1 | Break variant: 0 float, 1 driven at inactive level |
| dead_time | input | 8 | Dead-time in clock cycles |
| pin_main | output | 1 | Main pin level |
| pin_main_oe | output | 1 | Main pin tristate enable |
| pin_comp | output | 1 | Complementary pin level |
| pin_comp_oe | output | 1 | Complementary pin tristate enable |
| idle_conflict | output | 1 | Idle levels would make both outputs active |
| unused_cfg_err | output | 1 | Unused pair has non-zero polarity or idle bits |

## Verification
Several rules are checked on every cycle:
- the forced polarity levels while break is high,
- the enable rules of both break variants and of an unused pair,
- the idle levels throughout the idle phase,
- the absence of overlap between the two outputs in normal running,
- the inactive state on the first cycle after release.

Only the directed scenarios can show the exact edge counts. These are the three-edge synchronizer latency, the max(`dead_time`,1) spacing before idle and before a newly active output, the zero dead-time corner, and reset out of the idle phase. The two configuration flags are also checked only by the scenarios, across several polarity and idle combinations.

// File: rtl/cpair_brk_pkg.sv
package cpair_brk_pkg;

    typedef enum logic [1:0] {
        PH_NORMAL = 2'd0,
        PH_FORCED = 2'd1,
        PH_IDLE   = 2'd2
    } brk_phase_t;

    typedef struct packed {
        logic main;
        logic comp;
    } pair_t;

    // An output is at its active level when its pin differs from its polarity.
    function automatic logic at_active(input logic lvl, input logic pol);
        return lvl ^ pol;
    endfunction

    // Pin levels in normal operation from the active indications.
    function automatic pair_t drive_level(input pair_t on, input pair_t pol);
        pair_t r;
        r.main = on.main ^ pol.main;
        r.comp = on.comp ^ pol.comp;
        return r;
    endfunction

endpackage

// File: rtl/cpair_brk_sync.sv
module cpair_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cpair_brk_seq.sv
module cpair_brk_seq
    import cpair_brk_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            brk_s,
    input  logic [DT_W-1:0] dead_time,
    output brk_phase_t      phase
);
    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    logic [DT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_NORMAL;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_NORMAL: begin
                    if (brk_s) begin
                        phase <= PH_FORCED;
                        cnt   <= dead_time;
                    end
                end
                PH_FORCED: begin
                    if (!brk_s)              phase <= PH_NORMAL;
                    else if (cnt <= CNT_ONE) phase <= PH_IDLE;
                    else                     cnt   <= cnt - CNT_ONE;
                end
                PH_IDLE: begin
                    if (!brk_s) phase <= PH_NORMAL;
                end
                default: phase <= PH_NORMAL;
            endcase
        end
    end
endmodule

// File: rtl/cpair_dt_gen.sv
module cpair_dt_gen
    import cpair_brk_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            ref_in,
    input  logic [DT_W-1:0] dead_time,
    output pair_t           on
);
    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    logic            ref_d;
    logic [DT_W-1:0] gcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            on    <= '0;
            gcnt  <= '0;
            ref_d <= 1'b0;
        end else if (hold || (ref_in != ref_d)) begin
            // Break phase or reference edge: both off, restart the gap.
            on    <= '0;
            gcnt  <= dead_time;
            ref_d <= ref_in;
        end else if (gcnt > CNT_ONE) begin
            gcnt <= gcnt - CNT_ONE;
        end else begin
            gcnt    <= '0;
            on.main <= ref_in;
            on.comp <= !ref_in;
        end
    end
endmodule

// File: rtl/cpair_brk_ctrl.sv
module cpair_brk_ctrl
    import cpair_brk_pkg::*;
#(
    parameter int DT_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            brk_in,
    input  logic            oc_ref,
    input  logic            pol_main,
    input  logic            pol_comp,
    input  logic            idle_main,
    input  logic            idle_comp,
    input  logic            en_main,
    input  logic            en_comp,
    input  logic            off_sel,
    input  logic [DT_W-1:0] dead_time,
    output logic            pin_main,
    output logic            pin_main_oe,
    output logic            pin_comp,
    output logic            pin_comp_oe,
    output logic            idle_conflict,
    output logic            unused_cfg_err
);
    logic       brk_s;
    brk_phase_t phase;
    pair_t      on;
    pair_t      pol, idle, en, lvl, oe;
    logic       brk_hold;

    assign pol  = {pol_main, pol_comp};
    assign idle = {idle_main, idle_comp};
    assign en   = {en_main, en_comp};

    cpair_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (brk_in),
        .q   (brk_s)
    );

    cpair_brk_seq #(.DT_W(DT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .brk_s     (brk_s),
        .dead_time (dead_time),
        .phase     (phase)
    );

    cpair_dt_gen #(.DT_W(DT_W)) u_dt (
        .clk       (clk),
        .rst       (rst),
        .hold      (phase != PH_NORMAL),
        .ref_in    (oc_ref),
        .dead_time (dead_time),
        .on        (on)
    );

    // Raw break acts at once; the registered phase keeps it until release.
    assign brk_hold = brk_in || (phase != PH_NORMAL);

    always_comb begin
        if (phase == PH_IDLE) lvl = idle;
        else if (brk_hold)    lvl = pol;
        else                  lvl = drive_level(on, pol);

        oe = en;
        if (brk_hold && !off_sel) oe = '0;
    end

    assign pin_main    = lvl.main;
    assign pin_comp    = lvl.comp;
    assign pin_main_oe = oe.main;
    assign pin_comp_oe = oe.comp;

    assign idle_conflict  = at_active(idle.main, pol.main) && at_active(idle.comp, pol.comp);
    assign unused_cfg_err = (en == 2'b00) && ((pol != 2'b00) || (idle != 2'b00));
endmodule

// File: rtl/cpair_brk_ctrl_chk.sv
module cpair_brk_ctrl_chk
    import cpair_brk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       brk_in,
    input logic       pol_main,
    input logic       pol_comp,
    input logic       idle_main,
    input logic       idle_comp,
    input logic       en_main,
    input logic       en_comp,
    input logic       off_sel,
    input logic       pin_main,
    input logic       pin_main_oe,
    input logic       pin_comp,
    input logic       pin_comp_oe,
    input brk_phase_t phase
);
    assert_break_force_R1: assert property (@(posedge clk) disable iff (rst)
        (brk_in && phase != PH_IDLE) |-> (pin_main == pol_main && pin_comp == pol_comp));

    assert_break_float_R2: assert property (@(posedge clk) disable iff (rst)
        (brk_in && !off_sel) |-> (!pin_main_oe && !pin_comp_oe));

    assert_offstate_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (brk_in && off_sel) |-> (pin_main_oe == en_main && pin_comp_oe == en_comp));

    assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (pin_main == idle_main && pin_comp == idle_comp));

    assert_unused_float_R5: assert property (@(posedge clk) disable iff (rst)
        (!en_main && !en_comp) |-> (!pin_main_oe && !pin_comp_oe));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_NORMAL && !brk_in) |-> !((pin_main != pol_main) && (pin_comp != pol_comp)));

    assert_release_inactive_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) != PH_NORMAL && phase == PH_NORMAL && !brk_in)
            |-> (pin_main == pol_main && pin_comp == pol_comp));
endmodule

bind cpair_brk_ctrl cpair_brk_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .brk_in      (brk_in),
    .pol_main    (pol_main),
    .pol_comp    (pol_comp),
    .idle_main   (idle_main),
    .idle_comp   (idle_comp),
    .en_main     (en_main),
    .en_comp     (en_comp),
    .off_sel     (off_sel),
    .pin_main    (pin_main),
    .pin_main_oe (pin_main_oe),
    .pin_comp    (pin_comp),
    .pin_comp_oe (pin_comp_oe),
    .phase       (phase)
);

// File: tb/cpair_brk_ctrl_test.sv
`timescale 1ns/1ps
module cpair_brk_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       brk_in = 1'b0, oc_ref = 1'b0;
    logic       pol_main = 1'b0, pol_comp = 1'b0;
    logic       idle_main = 1'b0, idle_comp = 1'b0;
    logic       en_main = 1'b1, en_comp = 1'b1, off_sel = 1'b0;
    logic [7:0] dead_time = 8'd0;
    logic       pin_main, pin_main_oe, pin_comp, pin_comp_oe;
    logic       idle_conflict, unused_cfg_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cpair_brk_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .brk_in         (brk_in),
        .oc_ref         (oc_ref),
        .pol_main       (pol_main),
        .pol_comp       (pol_comp),
        .idle_main      (idle_main),
        .idle_comp      (idle_comp),
        .en_main        (en_main),
        .en_comp        (en_comp),
        .off_sel        (off_sel),
        .dead_time      (dead_time),
        .pin_main       (pin_main),
        .pin_main_oe    (pin_main_oe),
        .pin_comp       (pin_comp),
        .pin_comp_oe    (pin_comp_oe),
        .idle_conflict  (idle_conflict),
        .unused_cfg_err (unused_cfg_err)
    );

    // Advance n rising edges, then settle 5 ns past the edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic check2(input string req, input string what,
                          input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        pol_main = 1'b1; pol_comp = 1'b0; en_main = 1'b1; en_comp = 1'b1;
        step(3);
        check2("R11", "pins in reset", {pin_main, pin_comp}, 2'b10);
        check2("R11", "enables in reset", {pin_main_oe, pin_comp_oe}, 2'b11);
        pol_main = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_normal_deadtime;
        dead_time = 8'd4; oc_ref = 1'b0;
        step(8);
        check2("R8", "settled comp active", {pin_main, pin_comp}, 2'b01);
        oc_ref = 1'b1;
        step(1);
        check2("R9", "gap after rise", {pin_main, pin_comp}, 2'b00);
        step(3);
        check2("R9", "still gap at dt-1", {pin_main, pin_comp}, 2'b00);
        step(1);
        check2("R9", "main on at dt", {pin_main, pin_comp}, 2'b10);
        oc_ref = 1'b0;
        step(1);
        check2("R9", "gap after fall", {pin_main, pin_comp}, 2'b00);
        step(4);
        check2("R9", "comp on at dt", {pin_main, pin_comp}, 2'b01);
        pol_main = 1'b1;
        #1;
        check2("R8", "inverted main polarity", {pin_main, pin_comp}, 2'b11);
        pol_main = 1'b0;
    endtask

    task automatic t_break_float;
        off_sel = 1'b0; idle_main = 1'b0; idle_comp = 1'b1;
        dead_time = 8'd3; oc_ref = 1'b1;
        step(8);
        check2("R8", "main active before break", {pin_main, pin_comp}, 2'b10);
        brk_in = 1'b1;
        #1;
        check2("R1", "async force to polarity", {pin_main, pin_comp}, 2'b00);
        check2("R2", "float enables async", {pin_main_oe, pin_comp_oe}, 2'b00);
        step(5);
        check2("R4", "forced before dead-time end", {pin_main, pin_comp}, 2'b00);
        step(1);
        check2("R4", "idle levels after dead-time", {pin_main, pin_comp}, 2'b01);
        check2("R2", "float enables in idle", {pin_main_oe, pin_comp_oe}, 2'b00);
        brk_in = 1'b0;
        step(2);
        check2("R10", "idle held during sync", {pin_main, pin_comp}, 2'b01);
        step(1);
        check2("R10", "inactive on return", {pin_main, pin_comp}, 2'b00);
        check2("R10", "enables back", {pin_main_oe, pin_comp_oe}, 2'b11);
        step(2);
        check2("R10", "gap before main", {pin_main, pin_comp}, 2'b00);
        step(1);
        check2("R10", "main on after gap", {pin_main, pin_comp}, 2'b10);
    endtask

    task automatic t_break_offstate;
        off_sel = 1'b1; en_main = 1'b1; en_comp = 1'b0;
        idle_main = 1'b0; idle_comp = 1'b1; dead_time = 8'd0; oc_ref = 1'b1;
        step(8);
        brk_in = 1'b1;
        #1;
        check2("R1", "async force off-state", {pin_main, pin_comp}, 2'b00);
        check2("R3", "enables kept", {pin_main_oe, pin_comp_oe}, 2'b10);
        step(3);
        check2("R4", "forced at entry, dt 0", {pin_main, pin_comp}, 2'b00);
        step(1);
        check2("R4", "idle one edge later, dt 0", {pin_main, pin_comp}, 2'b01);
        check2("R3", "enables kept in idle", {pin_main_oe, pin_comp_oe}, 2'b10);
        brk_in = 1'b0;
        step(3);
        check2("R10", "inactive on return dt 0", {pin_main, pin_comp}, 2'b00);
        step(1);
        check2("R10", "main on one edge later", {pin_main, pin_comp}, 2'b10);
        en_comp = 1'b1;
    endtask

    task automatic t_unused;
        en_main = 1'b0; en_comp = 1'b0; off_sel = 1'b1;
        pol_main = 1'b0; pol_comp = 1'b0; idle_main = 1'b0; idle_comp = 1'b0;
        step(2);
        check2("R5", "unused enables normal", {pin_main_oe, pin_comp_oe}, 2'b00);
        check2("R7", "clean unused pair", {1'b0, unused_cfg_err}, 2'b00);
        brk_in = 1'b1;
        #1;
        check2("R5", "unused enables in break", {pin_main_oe, pin_comp_oe}, 2'b00);
        brk_in = 1'b0;
        step(6);
        pol_comp = 1'b1;
        #1;
        check2("R7", "polarity set on unused pair", {1'b0, unused_cfg_err}, 2'b01);
        en_main = 1'b1;
        #1;
        check2("R7", "pair in use", {1'b0, unused_cfg_err}, 2'b00);
        pol_comp = 1'b0; en_comp = 1'b1; off_sel = 1'b0;
    endtask

    task automatic t_conflict;
        pol_main = 1'b0; pol_comp = 1'b0; idle_main = 1'b1; idle_comp = 1'b1;
        #1;
        check2("R6", "both idle active, pol 00", {1'b0, idle_conflict}, 2'b01);
        idle_comp = 1'b0;
        #1;
        check2("R6", "one idle active", {1'b0, idle_conflict}, 2'b00);
        pol_main = 1'b1; pol_comp = 1'b1; idle_main = 1'b0; idle_comp = 1'b0;
        #1;
        check2("R6", "both idle active, pol 11", {1'b0, idle_conflict}, 2'b01);
        idle_comp = 1'b1;
        #1;
        check2("R6", "comp idle inactive, pol 11", {1'b0, idle_conflict}, 2'b00);
        pol_main = 1'b0; pol_comp = 1'b0; idle_main = 1'b0; idle_comp = 1'b0;
        step(1);
    endtask

    task automatic t_reset_from_idle;
        off_sel = 1'b0; idle_main = 1'b0; idle_comp = 1'b1; dead_time = 8'd2;
        step(4);
        brk_in = 1'b1;
        step(5);
        check2("R4", "idle reached before reset", {pin_main, pin_comp}, 2'b01);
        brk_in = 1'b0;
        rst = 1'b1;
        step(1);
        check2("R11", "reset leaves idle", {pin_main, pin_comp}, 2'b00);
        check2("R11", "enables after reset", {pin_main_oe, pin_comp_oe}, 2'b11);
        rst = 1'b0;
        idle_comp = 1'b0;
        step(2);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normal_deadtime();
        t_break_float();
        t_break_offstate();
        t_unused();
        t_conflict();
        t_reset_from_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule